// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of a raw 8-bit NAND bus and carries out one page program from start to finish. The host gives a row address and then one or more column segments. Each segment has a start column, a byte count and a flag that marks the last segment. The bytes themselves arrive on a separate valid/ready stream. The sequencer sends the opening load command, the full five-byte address and the first segment's bytes. For each further segment it sends a column-jump command with a fresh two-byte column. After the last segment it writes the launch command.

Once the launch command is out, the sequencer waits a short settling time and then watches the ready/busy line. A programmable cycle limit bounds this wait. When the device is ready again, the sequencer issues a status command, reads one status byte and reports pass or fail. If the wait runs out first, it reports a timeout and reads no status.

Pages in one erase block must be written in rising order. The block remembers the most recent page it launched, together with the block that page belongs to. A request that would go backwards in that block is refused before any bus activity.

Top module: `nand_prog_seq`

## Requirements
- R1: While reset is asserted and right after it, the sequencer idles. Both strobes `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, `done` is low and `req_ready` is high.
- R2: The first segment of a request produces, in order:
  - a command cycle 0x80 (CLE=1, ALE=0);
  - five address cycles (ALE=1, CLE=0) carrying column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8 and row bits 23:16;
  - one data cycle (CLE=0, ALE=0) for each segment byte, in stream order.
- R3: Each later segment produces a command cycle 0x85, then two address cycles with column bits 7:0 and then bits 15:8, then its data cycles.
- R4: Right after the data of the segment flagged last, the sequencer writes the command cycle 0x10.
- R5: Each bus write holds `nand_we_n` low for WE_LO clocks and then high for WE_HI clocks, with CLE, ALE and the data bus held throughout. The status read holds `nand_re_n` low for WE_LO clocks. The two strobes are never low together.
- R6: After the 0x10 command the sequencer waits TWB_CYC clocks and then waits for `nand_rb_n` to be high. It pulses no strobe during this wait. A device that never pulls the line low is handled the same way.
- R7: If `nand_rb_n` stays low after the settling time for more than `busy_limit` clocks, the sequencer pulses `done` together with `err_timeout`. It issues no status command.
- R8: Once the device is ready, the sequencer writes command 0x70 and then makes exactly one read cycle, sampling `nand_dq_in`.
- R9: `done` lasts one clock. `pass` is high with it only when status bit 6 is 1 and status bit 0 is 0. At most one of `pass`, `err_order` and `err_timeout` is high, and only together with `done`.
- R10: The block number is the row shifted right by PAGE_BITS; the page is the low PAGE_BITS of the row.
  - A request in the same block as the last launched page, with a page lower than or equal to it, is refused. The refusal is a `done` pulse with `err_order` and no bus cycle at all.
  - A page counts as launched once 0x10 is written, whatever the later outcome.
  - Only the most recent block is remembered, so returning to an earlier block is accepted.
- R11: A segment of length zero sends its command and address cycles and no data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New program request |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_row | input | ROW_W | Row (block and page) address |
| seg_valid | input | 1 | Segment descriptor valid |
| seg_ready | output | 1 | Sequencer waiting for a segment descriptor |
| seg_col | input | COL_W | Segment start column |
| seg_len | input | LEN_W | Segment byte count |
| seg_last | input | 1 | Segment is the final one before launch |
| dat_valid | input | 1 | Data byte valid |
| dat_ready | output | 1 | Sequencer taking a data byte |
| dat_byte | input | 8 | Data byte |
| busy_limit | input | TO_W | Maximum busy clocks before timeout |
| done | output | 1 | One-clock completion pulse |
| pass | output | 1 | Program succeeded (with done) |
| err_order | output | 1 | Request refused for page order (with done) |
| err_timeout | output | 1 | Busy wait timed out (with done) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Bus data from the device |
| nand_rb_n | input | 1 | Device ready (high) / busy (low) |

## Verification
The hardest case to reach is the one where the page-order memory must already hold a page that was launched but never confirmed good. The bench gets there by letting a busy-hold device model time out on one page and then asking for that same page again. It also sends a request that jumps to another block and then comes back to a low page of the earlier block, which shows that only the latest block is kept. A three-segment request whose final segment has length zero checks the column-jump path and the launch that follows right after an address phase.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_JUMP   = 8'h85;
  localparam logic [7:0] OP_LAUNCH = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;

  localparam int ST_READY_BIT = 6;
  localparam int ST_FAIL_BIT  = 0;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_REFUSE,
    SQ_SEG,
    SQ_CMD,
    SQ_ADDR,
    SQ_DATA,
    SQ_LAUNCH,
    SQ_BUSY,
    SQ_TOUT,
    SQ_SCMD,
    SQ_SREAD,
    SQ_FIN
  } seq_state_t;

endpackage

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine #(
  parameter int LO = 2,
  parameter int HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       rd,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] dat_i,
  input  logic [7:0] dq_in,
  output logic       fin,
  output logic       we_n,
  output logic       re_n,
  output logic       cle,
  output logic       ale,
  output logic       dq_oe,
  output logic [7:0] dq_out,
  output logic [7:0] rdata
);

  localparam int MX = (LO > HI) ? LO : HI;
  localparam int CW = $clog2(MX + 1);

  logic          act_q, act_d;
  logic          hi_q, hi_d;
  logic          rd_q, rd_d;
  logic          cle_q, cle_d;
  logic          ale_q, ale_d;
  logic [7:0]    dat_q, dat_d;
  logic [7:0]    rdat_q, rdat_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    hi_d   = hi_q;
    rd_d   = rd_q;
    cle_d  = cle_q;
    ale_d  = ale_q;
    dat_d  = dat_q;
    rdat_d = rdat_q;
    cnt_d  = cnt_q;
    fin    = 1'b0;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        hi_d  = 1'b0;
        cnt_d = '0;
        rd_d  = rd;
        cle_d = cle_i;
        ale_d = ale_i;
        dat_d = dat_i;
      end
    end else if (!hi_q) begin
      if (cnt_q == CW'(LO - 1)) begin
        hi_d  = 1'b1;
        cnt_d = '0;
        if (rd_q) rdat_d = dq_in;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == CW'(HI - 1)) begin
        act_d = 1'b0;
        cnt_d = '0;
        fin   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      rd_q   <= 1'b0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      dat_q  <= '0;
      rdat_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      hi_q   <= hi_d;
      rd_q   <= rd_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      dat_q  <= dat_d;
      rdat_q <= rdat_d;
      cnt_q  <= cnt_d;
    end
  end

  assign we_n   = ~(act_q & ~hi_q & ~rd_q);
  assign re_n   = ~(act_q & ~hi_q & rd_q);
  assign cle    = act_q & cle_q;
  assign ale    = act_q & ale_q;
  assign dq_oe  = act_q & ~rd_q;
  assign dq_out = act_q ? dat_q : 8'h00;
  assign rdata  = rdat_q;

  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe); // R5

endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int TWB  = 4,
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rb_n,
  input  logic [TO_W-1:0] limit,
  output logic            ready,
  output logic            tout
);

  localparam int WBW = $clog2(TWB + 2);

  logic             rb_m, rb_s;
  logic             on_q, on_d;
  logic [WBW-1:0]   wb_q, wb_d;
  logic [TO_W-1:0]  to_q, to_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b1;
      rb_s <= 1'b1;
    end else begin
      rb_m <= rb_n;
      rb_s <= rb_m;
    end
  end

  always_comb begin
    on_d  = on_q;
    wb_d  = wb_q;
    to_d  = to_q;
    ready = 1'b0;
    tout  = 1'b0;
    if (start) begin
      on_d = 1'b1;
      wb_d = '0;
      to_d = '0;
    end else if (on_q) begin
      if (wb_q != WBW'(TWB)) begin
        wb_d = wb_q + 1'b1;
      end else if (rb_s) begin
        ready = 1'b1;
        on_d  = 1'b0;
      end else if (to_q == limit) begin
        tout = 1'b1;
        on_d = 1'b0;
      end else begin
        to_d = to_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      wb_q <= '0;
      to_q <= '0;
    end else begin
      on_q <= on_d;
      wb_q <= wb_d;
      to_q <= to_d;
    end
  end

  AST_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !on_q); // R6
  AST_READY_TOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && tout)); // R7
  AST_TOUT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tout |-> !rb_s); // R7

endmodule

// File: rtl/nand_page_order.sv
module nand_page_order #(
  parameter int ROW_W     = 24,
  parameter int PAGE_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic             commit,
  output logic             refuse
);

  localparam int BLK_W = ROW_W - PAGE_BITS;

  logic                 vld_q;
  logic [BLK_W-1:0]     blk_q;
  logic [PAGE_BITS-1:0] pg_q;
  logic [BLK_W-1:0]     blk_in;
  logic [PAGE_BITS-1:0] pg_in;
  logic                 same_blk;

  assign blk_in   = row[ROW_W-1:PAGE_BITS];
  assign pg_in    = row[PAGE_BITS-1:0];
  assign same_blk = vld_q && (blk_in == blk_q);
  assign refuse   = same_blk && (pg_in <= pg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      blk_q <= '0;
      pg_q  <= '0;
    end else if (commit) begin
      vld_q <= 1'b1;
      blk_q <= blk_in;
      pg_q  <= pg_in;
    end
  end

  AST_COMMIT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && vld_q && blk_in == blk_q) |-> (pg_in > pg_q)); // R10

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nand_seq_pkg::*;
#(
  parameter int ROW_W     = 24,
  parameter int COL_W     = 16,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 6,
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 2,
  parameter int TWB_CYC   = 4,
  parameter int TO_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [COL_W-1:0] seg_col,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [7:0]       dat_byte,
  input  logic [TO_W-1:0]  busy_limit,
  output logic             done,
  output logic             pass,
  output logic             err_order,
  output logic             err_timeout,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);

  localparam int COL_BYTES = COL_W / 8;
  localparam int ROW_BYTES = ROW_W / 8;
  localparam int ALL_BYTES = COL_BYTES + ROW_BYTES;
  localparam int AW        = $clog2(ALL_BYTES + 1);
  localparam int WW        = ROW_W + COL_W;

  seq_state_t       st_q, st_d;
  logic             pend_q, pend_d;
  logic             first_q, first_d;
  logic             last_q, last_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [AW-1:0]    acnt_q, acnt_d;

  logic             go, rd, cle_i, ale_i, fin;
  logic [7:0]       dout, rdata, addr_byte;
  logic             commit, watch_start, rb_ready, rb_tout, refuse;
  logic [WW-1:0]    addr_word;
  logic [AW-1:0]    addr_last;

  assign addr_word = {row_q, col_q};
  assign addr_byte = addr_word[{acnt_q, 3'b000} +: 8];
  assign addr_last = first_q ? AW'(ALL_BYTES - 1) : AW'(COL_BYTES - 1);

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    first_d     = first_q;
    last_d      = last_q;
    row_d       = row_q;
    col_d       = col_q;
    len_d       = len_q;
    acnt_d      = acnt_q;
    go          = 1'b0;
    rd          = 1'b0;
    cle_i       = 1'b0;
    ale_i       = 1'b0;
    dout        = 8'h00;
    commit      = 1'b0;
    watch_start = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          row_d   = req_row;
          first_d = 1'b1;
          st_d    = SQ_CHECK;
        end
      end
      SQ_CHECK:  st_d = refuse ? SQ_REFUSE : SQ_SEG;
      SQ_REFUSE: st_d = SQ_IDLE;
      SQ_SEG: begin
        if (seg_valid) begin
          col_d  = seg_col;
          len_d  = seg_len;
          last_d = seg_last;
          acnt_d = '0;
          st_d   = SQ_CMD;
        end
      end
      SQ_CMD: begin
        cle_i = 1'b1;
        dout  = first_q ? OP_LOAD : OP_JUMP;
        if (!pend_q) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d = 1'b0;
          st_d   = SQ_ADDR;
        end
      end
      SQ_ADDR: begin
        ale_i = 1'b1;
        dout  = addr_byte;
        if (!pend_q) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d = 1'b0;
          if (acnt_q == addr_last) begin
            acnt_d  = '0;
            first_d = 1'b0;
            if (len_q != '0) st_d = SQ_DATA;
            else             st_d = last_q ? SQ_LAUNCH : SQ_SEG;
          end else begin
            acnt_d = acnt_q + 1'b1;
          end
        end
      end
      SQ_DATA: begin
        dout = dat_byte;
        if (!pend_q && dat_valid) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d = 1'b0;
          len_d  = len_q - 1'b1;
          if (len_q == LEN_W'(1)) st_d = last_q ? SQ_LAUNCH : SQ_SEG;
        end
      end
      SQ_LAUNCH: begin
        cle_i = 1'b1;
        dout  = OP_LAUNCH;
        if (!pend_q) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d      = 1'b0;
          commit      = 1'b1;
          watch_start = 1'b1;
          st_d        = SQ_BUSY;
        end
      end
      SQ_BUSY: begin
        if (rb_tout)       st_d = SQ_TOUT;
        else if (rb_ready) st_d = SQ_SCMD;
      end
      SQ_TOUT: st_d = SQ_IDLE;
      SQ_SCMD: begin
        cle_i = 1'b1;
        dout  = OP_STATUS;
        if (!pend_q) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d = 1'b0;
          st_d   = SQ_SREAD;
        end
      end
      SQ_SREAD: begin
        rd = 1'b1;
        if (!pend_q) begin
          go     = 1'b1;
          pend_d = 1'b1;
        end
        if (fin) begin
          pend_d = 1'b0;
          st_d   = SQ_FIN;
        end
      end
      SQ_FIN:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      acnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      first_q <= first_d;
      last_q  <= last_d;
      row_q   <= row_d;
      col_q   <= col_d;
      len_q   <= len_d;
      acnt_q  <= acnt_d;
    end
  end

  nand_cycle_engine #(.LO(WE_LO), .HI(WE_HI)) engine_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .rd     (rd),
    .cle_i  (cle_i),
    .ale_i  (ale_i),
    .dat_i  (dout),
    .dq_in  (nand_dq_in),
    .fin    (fin),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .dq_oe  (nand_dq_oe),
    .dq_out (nand_dq_out),
    .rdata  (rdata)
  );

  nand_rb_watch #(.TWB(TWB_CYC), .TO_W(TO_W)) watch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (watch_start),
    .rb_n  (nand_rb_n),
    .limit (busy_limit),
    .ready (rb_ready),
    .tout  (rb_tout)
  );

  nand_page_order #(.ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS)) order_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .row    (row_q),
    .commit (commit),
    .refuse (refuse)
  );

  assign req_ready   = (st_q == SQ_IDLE);
  assign seg_ready   = (st_q == SQ_SEG);
  assign dat_ready   = (st_q == SQ_DATA) && !pend_q;
  assign done        = (st_q == SQ_FIN) || (st_q == SQ_REFUSE) || (st_q == SQ_TOUT);
  assign pass        = (st_q == SQ_FIN) && rdata[ST_READY_BIT] && !rdata[ST_FAIL_BIT];
  assign err_order   = (st_q == SQ_REFUSE);
  assign err_timeout = (st_q == SQ_TOUT);

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BUSY) |-> (nand_we_n && nand_re_n)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, err_order, err_timeout})); // R9
  AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || err_order || err_timeout) |-> done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |-> $past(nand_we_n) && nand_we_n); // R10

endmodule

// File: tb/nand_prog_seq_tb_top.sv
`timescale 1ns/1ps
module nand_prog_seq_tb_top;

  localparam int WE_LO = 2;
  localparam int WE_HI = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_row;
  logic        seg_valid;
  logic        seg_ready;
  logic [15:0] seg_col;
  logic [11:0] seg_len;
  logic        seg_last;
  logic        dat_valid;
  logic        dat_ready;
  logic [7:0]  dat_byte;
  logic [15:0] busy_limit;
  logic        done, pass, err_order, err_timeout;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in;
  logic        nand_rb_n;

  always #2 clk = ~clk;

  nand_prog_seq #(.WE_LO(WE_LO), .WE_HI(WE_HI)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_col(seg_col),
    .seg_len(seg_len), .seg_last(seg_last),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .busy_limit(busy_limit),
    .done(done), .pass(pass), .err_order(err_order), .err_timeout(err_timeout),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int          exp_q[$];
  logic [28:0] seg_q[$];
  logic [7:0]  dat_q[$];
  int          reads = 0;
  int          dones = 0;
  int          busy_left = 0;
  int          busy_time = 0;
  logic [7:0]  stat_val = 8'h40;
  bit          ex_pass, ex_ord, ex_to;
  bit          in_flight = 0;
  bit          seg_fire = 0, dat_fire = 0;
  logic        prev_we = 1'b1, prev_re = 1'b1;
  int          we_lo_cnt = 0, re_lo_cnt = 0;
  int          seed = 3;
  int          cyc = 0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic int ev(bit c, bit a, logic [7:0] b);
    return {22'd0, c, a, b};
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-clock reference comparison, device model and stream drivers
  always @(negedge clk) begin
    if (rst_n) begin
      // R5: strobe widths and bus event capture on the rising write strobe
      if (!nand_we_n) we_lo_cnt++;
      if (!nand_re_n) re_lo_cnt++;
      if (!prev_we && nand_we_n) begin
        chk(we_lo_cnt == WE_LO, "R5", "we_n low width", we_lo_cnt, WE_LO);
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected bus write", ev(nand_cle, nand_ale, nand_dq_out), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(ev(nand_cle, nand_ale, nand_dq_out) == e, "R2/R3/R4",
              "bus write {cle,ale,dq}", ev(nand_cle, nand_ale, nand_dq_out), e);
        end
        if (nand_cle && nand_dq_out == 8'h10) busy_left = busy_time;
        we_lo_cnt = 0;
      end
      if (!prev_re && nand_re_n) begin
        chk(re_lo_cnt == WE_LO, "R5", "re_n low width", re_lo_cnt, WE_LO);
        reads++;
        re_lo_cnt = 0;
      end
      if (!nand_rb_n && (!nand_we_n || !nand_re_n))
        chk(0, "R6", "strobe while busy", 1, 0);
      if (!nand_we_n && !nand_re_n) chk(0, "R5", "both strobes low", 1, 0);
      // completion compared against the model's expectation
      if (done) begin
        dones++;
        chk(in_flight, "R9", "done without request", 1, 0);
        chk(pass == ex_pass, "R9", "pass", pass, ex_pass);
        chk(err_order == ex_ord, "R10", "err_order", err_order, ex_ord);
        chk(err_timeout == ex_to, "R7", "err_timeout", err_timeout, ex_to);
        in_flight = 0;
      end
      // device busy model
      if (busy_left > 0) begin
        nand_rb_n = 1'b0;
        busy_left--;
      end else begin
        nand_rb_n = 1'b1;
      end
      // segment and data stream drivers
      if (seg_fire) void'(seg_q.pop_front());
      if (dat_fire) void'(dat_q.pop_front());
      seg_valid = (seg_q.size() > 0);
      if (seg_valid) {seg_last, seg_len, seg_col} = seg_q[0];
      dat_valid = (dat_q.size() > 0);
      if (dat_valid) dat_byte = dat_q[0];
      seg_fire = seg_valid && seg_ready;
      dat_fire = dat_valid && dat_ready;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic add_seg(input logic [23:0] row, input logic [15:0] col,
                         input int len, input bit first, input bit last);
    if (first) begin
      exp_q.push_back(ev(1, 0, 8'h80));
      exp_q.push_back(ev(0, 1, col[7:0]));
      exp_q.push_back(ev(0, 1, col[15:8]));
      exp_q.push_back(ev(0, 1, row[7:0]));
      exp_q.push_back(ev(0, 1, row[15:8]));
      exp_q.push_back(ev(0, 1, row[23:16]));
    end else begin
      exp_q.push_back(ev(1, 0, 8'h85));
      exp_q.push_back(ev(0, 1, col[7:0]));
      exp_q.push_back(ev(0, 1, col[15:8]));
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      seed = seed * 37 + 11;
      b = 8'(seed);
      dat_q.push_back(b);
      exp_q.push_back(ev(0, 0, b));
    end
    seg_q.push_back({last, 12'(len), col});
    if (last) exp_q.push_back(ev(1, 0, 8'h10));
  endtask

  task automatic run(input logic [23:0] row, input logic [7:0] stat, input int busy,
                     input bit p, input bit o, input bit t, input string req);
    int exp_reads;
    int wait_n;
    int d0;
    stat_val   = stat;
    nand_dq_in = stat;
    busy_time  = busy;
    ex_pass = p; ex_ord = o; ex_to = t;
    exp_reads = (!o && !t) ? 1 : 0;
    if (!o && !t) exp_q.push_back(ev(1, 0, 8'h70));
    reads = 0;
    d0 = dones;
    @(negedge clk);
    req_row   = row;
    req_valid = 1'b1;
    in_flight = 1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 0;
    while (dones == d0 && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(dones == d0 + 1, req, "done count", dones - d0, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, "bus writes missing", exp_q.size(), 0);
    chk(reads == exp_reads, "R8", "status read cycles", reads, exp_reads);
    chk(seg_q.size() == 0 && dat_q.size() == 0, req, "stream left over",
        seg_q.size() + dat_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_row    = '0;
    seg_valid  = 1'b0;
    seg_col    = '0;
    seg_len    = '0;
    seg_last   = 1'b0;
    dat_valid  = 1'b0;
    dat_byte   = '0;
    busy_limit = 16'd200;
    nand_dq_in = 8'h40;
    nand_rb_n  = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
        "R1", "bus idle in reset",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    chk(!done && req_ready, "R1", "done/ready in reset", {done, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_we_n && req_ready && !done, "R1", "after release",
        {nand_we_n, req_ready, done}, 3'b110);

    // R2 R4 R8 R9: single segment, pass
    add_seg(24'h012345, 16'h0010, 4, 1, 1);
    run(24'h012345, 8'h40, 20, 1, 0, 0, "R2");

    // R3 R11: three segments, last has length zero; extra status bits ignored
    add_seg(24'h012347, 16'h0000, 3, 1, 0);
    add_seg(24'h012347, 16'h0200, 2, 0, 0);
    add_seg(24'h012347, 16'h0134, 0, 0, 1);
    run(24'h012347, 8'hC0, 15, 1, 0, 0, "R3");

    // R10: same page and lower page in the same block refused
    run(24'h012347, 8'h40, 0, 0, 1, 0, "R10");
    run(24'h012340, 8'h40, 0, 0, 1, 0, "R10");

    // R9: status fail bit, and ready bit clear
    add_seg(24'h012348, 16'h0005, 2, 1, 1);
    run(24'h012348, 8'h41, 10, 0, 0, 0, "R9");
    add_seg(24'h01234A, 16'h0006, 1, 1, 1);
    run(24'h01234A, 8'h01, 10, 0, 0, 0, "R9");

    // R7: busy longer than the limit
    busy_limit = 16'd30;
    add_seg(24'h01234B, 16'h0001, 2, 1, 1);
    run(24'h01234B, 8'h40, 500, 0, 0, 1, "R7");
    while (!nand_rb_n) @(negedge clk);
    busy_limit = 16'd200;
    // R10: a timed-out page still counts as launched
    run(24'h01234B, 8'h40, 0, 0, 1, 0, "R10");

    // R10: other block accepted, then the earlier block at a low page accepted
    add_seg(24'h000080, 16'h0000, 1, 1, 1);
    run(24'h000080, 8'h40, 8, 1, 0, 0, "R10");
    // R6: device that never drops ready/busy
    add_seg(24'h012341, 16'h0003, 2, 1, 1);
    run(24'h012341, 8'h40, 0, 1, 0, 0, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule